// File: doc/BRIEF.md
# Masked ternary threshold neuron unit

This execution unit evaluates one threshold neuron for a custom instruction. Two register operands arrive with a start pulse. The low byte of the first operand is the binary input vector. The second operand packs three fields: an excitatory mask, an inhibitory mask and a small signed bias.

Every input bit that is set and also selected by the excitatory mask adds one to a running sum. Every input bit that is set and also selected by the inhibitory mask subtracts one. The bias is then added. The unit returns 1 when the total is zero or more, and 0 otherwise.

The result is zero-extended to the register width. It appears together with a one-cycle done pulse exactly two cycles after the start pulse. A new start may be issued on every cycle, so a stream of neuron evaluations runs at full rate. Layers of these neurons can be chained in software: an OR neuron and a NAND neuron feeding an AND neuron realise XOR.

Top module: `neuron_eval_unit`

## Requirements
- R1: The input vector is rs1[7:0]. Bits rs1[31:8] have no effect on the result.
- R2: The excitatory mask is rs2[7:0] and the inhibitory mask is rs2[15:8]. An input bit that is set in both masks contributes zero to the sum.
- R3: The bias is rs2[20:16], read as a 5-bit two's-complement value (range -16 to +15). Bits rs2[31:21] have no effect on the result.
- R4: result[0] is 1 exactly when popcount(x & excitatory) - popcount(x & inhibitory) + bias >= 0. The comparison is correct over the whole range -24 to +23.
- R5: result[31:1] is always zero.
- R6: done is high for exactly one cycle, two cycles after the cycle in which start was sampled high. done is never high otherwise.
- R7: Starts on consecutive cycles each produce their own result, in issue order, each with the latency of R6.
- R8: While reset is held, done and result are zero.
- R9: result holds its value in every cycle in which done is low.
- R10: Two layers of the unit, used as OR and NAND neurons feeding an AND neuron, compute XOR of two input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; operands are sampled while it is high |
| rs1 | input | 32 | First operand; the low byte is the input vector |
| rs2 | input | 32 | Second operand; holds both masks and the bias |
| done | output | 1 | One-cycle pulse that marks a valid result |
| result | output | 32 | Neuron output, 0 or 1, zero-extended |

## Verification
The bench builds the unit with its default parameters: 32-bit operands, an 8-bit input vector, a 5-bit bias and the rippled popcount variant. These values make both ends of the sum range reachable. Full excitation with a +15 bias reaches +23. Full inhibition with a -16 bias reaches -24. The sums of -1 and 0 on either side of the step can be produced with many different mask overlaps, including masks that fully cancel. A long back-to-back random stream fills both pipeline stages every cycle.

// File: rtl/neuron_eval_pkg.sv
package neuron_eval_pkg;

   // Popcount implementation variant
   typedef enum logic [0:0] {
      PC_RIPPLE = 1'b0,   // chained adders built by generate
      PC_LOOP   = 1'b1    // behavioural loop, left to synthesis
   } pc_style_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/neuron_operand_split.sv
module neuron_operand_split #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned BIAS_W = 5
) (
   input  logic [XLEN-1:0]   rs1,
   input  logic [XLEN-1:0]   rs2,
   output logic [VEC_W-1:0]  exc_hits,
   output logic [VEC_W-1:0]  inh_hits,
   output logic [BIAS_W-1:0] bias_raw
);
   localparam int unsigned INH_LSB  = VEC_W;
   localparam int unsigned BIAS_LSB = 2 * VEC_W;
   localparam int unsigned USED_W   = BIAS_LSB + BIAS_W;

   logic [VEC_W-1:0] in_vec;

   assign in_vec   = rs1[VEC_W-1:0];
   assign exc_hits = in_vec & rs2[VEC_W-1:0];
   assign inh_hits = in_vec & rs2[INH_LSB +: VEC_W];
   assign bias_raw = rs2[BIAS_LSB +: BIAS_W];

   // Upper operand bits are deliberately ignored
   generate
      if (XLEN > USED_W) begin : g_spare2
         logic unused_rs2_hi;
         assign unused_rs2_hi = ^rs2[XLEN-1:USED_W];
      end
      if (XLEN > VEC_W) begin : g_spare1
         logic unused_rs1_hi;
         assign unused_rs1_hi = ^rs1[XLEN-1:VEC_W];
      end
   endgenerate
endmodule

// File: rtl/neuron_popcount.sv
module neuron_popcount
   import neuron_eval_pkg::*;
#(
   parameter int unsigned W     = 8,
   parameter pc_style_e   STYLE = PC_RIPPLE,
   parameter int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     bits_i,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (STYLE == PC_RIPPLE) begin : g_ripple
         for (genvar i = 0; i < W; i++) begin : g_stage
            logic [CNT_W-1:0] acc;
            if (i == 0) begin : g_first
               assign acc = CNT_W'(bits_i[0]);
            end else begin : g_next
               assign acc = g_stage[i-1].acc + CNT_W'(bits_i[i]);
            end
         end
         assign count_o = g_stage[W-1].acc;
      end else begin : g_loop
         always_comb begin
            count_o = '0;
            for (int i = 0; i < W; i++) begin
               count_o = count_o + CNT_W'(bits_i[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/neuron_step_stage.sv
module neuron_step_stage #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned BIAS_W = 5,
   parameter int unsigned SUM_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [CNT_W-1:0]  exc_cnt_i,
   input  logic [CNT_W-1:0]  inh_cnt_i,
   input  logic [BIAS_W-1:0] bias_i,
   output logic              done_o,
   output logic [XLEN-1:0]   result_o
);
   logic [SUM_W-1:0] exc_ext;
   logic [SUM_W-1:0] inh_ext;
   logic [SUM_W-1:0] bias_ext;
   logic [SUM_W-1:0] sum;
   logic             fire;

   always_comb begin
      exc_ext  = {{(SUM_W-CNT_W){1'b0}}, exc_cnt_i};
      inh_ext  = {{(SUM_W-CNT_W){1'b0}}, inh_cnt_i};
      bias_ext = {{(SUM_W-BIAS_W){bias_i[BIAS_W-1]}}, bias_i};
      sum      = exc_ext - inh_ext + bias_ext;
      fire     = ~sum[SUM_W-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         result_o <= '0;
      end else begin
         done_o <= valid_i;
         if (valid_i) begin
            result_o <= {{(XLEN-1){1'b0}}, fire};
         end
      end
   end
endmodule

// File: rtl/neuron_eval_unit.sv
module neuron_eval_unit
   import neuron_eval_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned BIAS_W   = 5,
   parameter pc_style_e   PC_STYLE = PC_RIPPLE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [XLEN-1:0] rs1,
   input  logic [XLEN-1:0] rs2,
   output logic            done,
   output logic [XLEN-1:0] result
);
   localparam int unsigned CNT_W = $clog2(VEC_W + 1);
   localparam int unsigned SUM_W = max2(CNT_W, BIAS_W) + 2;

   // Elaboration-time parameter checks
   generate
      if (VEC_W < 1) begin : g_bad_vec
         $error("VEC_W must be at least 1");
      end
      if (BIAS_W < 2) begin : g_bad_bias
         $error("BIAS_W must be at least 2");
      end
      if (XLEN < 2 * VEC_W + BIAS_W) begin : g_bad_xlen
         $error("XLEN too small for the packed operand fields");
      end
   endgenerate

   logic [VEC_W-1:0]  exc_hits;
   logic [VEC_W-1:0]  inh_hits;
   logic [BIAS_W-1:0] bias_raw;
   logic [CNT_W-1:0]  exc_cnt;
   logic [CNT_W-1:0]  inh_cnt;

   neuron_operand_split #(
      .XLEN  (XLEN),
      .VEC_W (VEC_W),
      .BIAS_W(BIAS_W)
   ) split_i (
      .rs1     (rs1),
      .rs2     (rs2),
      .exc_hits(exc_hits),
      .inh_hits(inh_hits),
      .bias_raw(bias_raw)
   );

   neuron_popcount #(.W(VEC_W), .STYLE(PC_STYLE), .CNT_W(CNT_W)) exc_pc_i (
      .bits_i (exc_hits),
      .count_o(exc_cnt)
   );

   neuron_popcount #(.W(VEC_W), .STYLE(PC_STYLE), .CNT_W(CNT_W)) inh_pc_i (
      .bits_i (inh_hits),
      .count_o(inh_cnt)
   );

   // Stage 1: counts and bias
   logic              s1_valid;
   logic [CNT_W-1:0]  s1_exc;
   logic [CNT_W-1:0]  s1_inh;
   logic [BIAS_W-1:0] s1_bias;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_exc   <= '0;
         s1_inh   <= '0;
         s1_bias  <= '0;
      end else begin
         s1_valid <= start;
         if (start) begin
            s1_exc  <= exc_cnt;
            s1_inh  <= inh_cnt;
            s1_bias <= bias_raw;
         end
      end
   end

   // Stage 2: signed sum and step
   neuron_step_stage #(
      .XLEN  (XLEN),
      .CNT_W (CNT_W),
      .BIAS_W(BIAS_W),
      .SUM_W (SUM_W)
   ) step_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (s1_valid),
      .exc_cnt_i(s1_exc),
      .inh_cnt_i(s1_inh),
      .bias_i   (s1_bias),
      .done_o   (done),
      .result_o (result)
   );
endmodule

// File: rtl/neuron_eval_unit_chk.sv
module neuron_eval_unit_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned BIAS_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [XLEN-1:0] rs1,
   input logic [XLEN-1:0] rs2,
   input logic            done,
   input logic [XLEN-1:0] result
);
   // Cycles since reset release, saturating at 2
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n)         warm <= 2'd0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   function automatic logic model_fire(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
      int acc;
      logic [BIAS_W-1:0] bf;
      acc = 0;
      for (int i = 0; i < VEC_W; i++) begin
         if (a[i] && b[i])         acc = acc + 1;
         if (a[i] && b[VEC_W + i]) acc = acc - 1;
      end
      bf = b[2*VEC_W +: BIAS_W];
      if (bf[BIAS_W-1]) acc = acc + int'(bf) - (1 << BIAS_W);
      else              acc = acc + int'(bf);
      return (acc >= 0);
   endfunction

   AST_RESULT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      result[XLEN-1:1] == '0); // R5

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2) |-> (done == $past(start, 2))); // R6

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm != 2'd0) && !done) |-> $stable(result)); // R9

   AST_STEP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm == 2'd2) && done) |-> (result[0] == model_fire($past(rs1, 2), $past(rs2, 2)))); // R4
endmodule

bind neuron_eval_unit neuron_eval_unit_chk #(
   .XLEN  (XLEN),
   .VEC_W (VEC_W),
   .BIAS_W(BIAS_W)
) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .rs1   (rs1),
   .rs2   (rs2),
   .done  (done),
   .result(result)
);

// File: tb/neuron_eval_unit_tb_top.sv
`timescale 1ns/1ps
module neuron_eval_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] rs1 = '0;
   logic [31:0] rs2 = '0;
   logic        done;
   logic [31:0] result;

   always #4 clk = ~clk;   // 125 MHz

   neuron_eval_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rs1(rs1), .rs2(rs2), .done(done), .result(result)
   );

   typedef struct {
      logic  exp;
      int    due;
      string tag;
   } item_t;

   item_t       sbq[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   logic        last_res = 1'b0;
   logic [31:0] held = '0;
   logic        mon_on = 1'b0;
   logic        finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic ref_fire(input logic [31:0] a, input logic [31:0] b);
      int s;
      s = 0;
      for (int i = 0; i < 8; i++) begin
         if (a[i] && b[i])     s = s + 1;
         if (a[i] && b[8 + i]) s = s - 1;
      end
      if (b[20]) s = s + int'(b[20:16]) - 32;
      else       s = s + int'(b[20:16]);
      return (s >= 0);
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (mon_on) begin
         if (done) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R6 spurious done", 32'd1, 32'd0);
            end else begin
               item_t it;
               it = sbq.pop_front();
               check(it.due == cyc, {it.tag, " R6 latency"}, 32'(cyc), 32'(it.due));
               check(result == {31'b0, it.exp}, it.tag, result, {31'b0, it.exp});
               check(result[31:1] == '0, "R5 zero-extend", result, {31'b0, result[0]});
               last_res = result[0];
            end
            held = result;
         end else begin
            check(result == held, "R9 hold", result, held);
            if (sbq.size() != 0 && sbq[0].due <= cyc) begin
               item_t it;
               it = sbq.pop_front();
               check(1'b0, {it.tag, " R6 missing done"}, 32'd0, 32'd1);
            end
         end
      end
   end

   task automatic issue(input logic [31:0] a, input logic [31:0] b, input string tag);
      item_t it;
      @(negedge clk);
      start = 1'b1;
      rs1   = a;
      rs2   = b;
      it.exp = ref_fire(a, b);
      it.due = cyc + 2;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   task automatic run_one(input logic [31:0] a, input logic [31:0] b, input string tag, output logic r);
      issue(a, b, tag);
      idle(1);
      while (sbq.size() != 0) @(negedge clk);
      r = last_res;
   endtask

   // Packs masks and bias into rs2
   function automatic logic [31:0] pk(input logic [7:0] exc, input logic [7:0] inh, input logic [4:0] bias);
      return {11'b0, bias, inh, exc};
   endfunction

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic r, h1, h2, x;
      logic [31:0] seed;
      seed = 32'h1234_5678;

      repeat (3) @(negedge clk);
      check(done == 1'b0, "R8 done in reset", {31'b0, done}, 32'd0);
      check(result == '0, "R8 result in reset", result, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && result == '0, "R8 after release", result, 32'd0);
      mon_on = 1'b1;

      // Boundary sums around the step (R4)
      issue(32'h0, pk(8'h00, 8'h00, 5'h00), "R4 sum 0");
      issue(32'h0, pk(8'h00, 8'h00, 5'h1F), "R4 sum -1");
      issue(32'hFF, pk(8'hFF, 8'h00, 5'h0F), "R4 sum +23");
      issue(32'hFF, pk(8'h00, 8'hFF, 5'h10), "R4 sum -24");
      issue(32'hFF, pk(8'hFF, 8'h00, 5'h10), "R4 sum -8");
      issue(32'hFF, pk(8'h00, 8'hFF, 5'h0F), "R4 sum +7");
      issue(32'h0F, pk(8'h07, 8'h00, 5'h1D), "R4 sum 0 from 3-3");
      issue(32'h0F, pk(8'h03, 8'h00, 5'h1D), "R4 sum -1 from 2-3");
      idle(4);

      // Bit set in both masks cancels (R2)
      issue(32'hFF, pk(8'hFF, 8'hFF, 5'h1F), "R2 overlap sum -1");
      issue(32'hFF, pk(8'hFF, 8'hFF, 5'h00), "R2 overlap sum 0");
      issue(32'h81, pk(8'h81, 8'h01, 5'h1F), "R2 partial overlap");
      idle(4);

      // Upper operand bits have no effect (R1, R3)
      issue(32'hFFFF_FF00, pk(8'hFF, 8'h00, 5'h1F), "R1 rs1 high ignored");
      issue(32'h0000_0000 | 32'h5A5A_5A00, pk(8'h00, 8'hFF, 5'h00), "R1 rs1 high ignored 2");
      issue(32'h0000_0001, 32'hFFE0_0000 | pk(8'h00, 8'h01, 5'h00), "R3 rs2 high ignored");
      issue(32'h0000_0000, 32'hFFE0_0000 | pk(8'h00, 8'h00, 5'h10), "R3 bias sign");
      idle(6);

      // Two-layer XOR (R10)
      for (int a = 0; a < 2; a++) begin
         for (int b = 0; b < 2; b++) begin
            run_one({30'b0, 1'(b), 1'(a)}, pk(8'h03, 8'h00, 5'h1F), "R10 OR layer", h1);
            run_one({30'b0, 1'(b), 1'(a)}, pk(8'h00, 8'h03, 5'h01), "R10 NAND layer", h2);
            run_one({30'b0, h2, h1}, pk(8'h03, 8'h00, 5'h1E), "R10 AND layer", x);
            check(x == 1'(a ^ b), "R10 xor", {31'b0, x}, {31'b0, 1'(a ^ b)});
         end
      end
      idle(3);

      // Back-to-back random stream (R7)
      for (int k = 0; k < 300; k++) begin
         logic [31:0] a, b;
         seed = seed * 32'd1664525 + 32'd1013904223;
         a = seed;
         seed = seed * 32'd1664525 + 32'd1013904223;
         b = seed;
         issue(a, b, "R7 stream");
      end
      idle(8);
      check(sbq.size() == 0, "R7 drained", 32'(sbq.size()), 32'd0);

      finished = 1'b1;
      report();
   end
endmodule